// File: doc/BRIEF.md
# Clock-Embedded Command Link Master

This block drives the command side of a link in which short commands travel inside a distributed clock stream. A host asks it to send one of three node commands to one node on a shared multipoint bus: clear the node's logic, restart the node's processor, or step the node's time-cycle counter. The addressed node must return the same frame. The master treats that return both as the acknowledgement and as a timing sample. It counts clock cycles from launch to acceptance and keeps the result per node, so that delay correction can be tuned node by node.

Only one request is in flight at a time. A request that gets no valid echo within a fixed window ends with a timeout status. A rising edge on the periodic tick input makes the master send a time-cycle step to every node at once, on the broadcast address. Broadcasts expect no echo. Per-node loop delays can be read back through a synchronous read port.

Frames are 16 bits, sent one bit per clock, most significant bit first, on a line that idles low. Bits [15:12] hold the start pattern 1010, [11:8] the node address, [7:6] the command code, [5:4] a sequence tag, and [3:0] a check nibble equal to address XOR {command, tag}. Address 1111 is the broadcast address.

Top module: `cmd_link_master`

## Requirements
- R1: Frames leave on tx_line MSB first, one bit per clock, in the layout 1010 / address[11:8] / command[7:6] / tag[5:4] / check[3:0], where check = address ^ {command, tag}. The line is low whenever no frame is being sent. Command codes are 00 node logic reset, 01 processor reboot, 10 cycle increment and 11 reserved, and the code is sent exactly as the host gives it.
- R2: After reset, req_ready is 1, tx_line is 0, both status pulses are 0, and every delay table entry reads 0.
- R3: Each unicast request carries a 2-bit tag that starts at 00 after reset and rises by one per unicast launch, wrapping around. Broadcast frames always carry tag 00 and do not advance the tag.
- R4: A returned frame identical to the one sent produces a one-cycle done_ack pulse and writes the node's table entry. The value written is the number of clock edges from the launching edge to the accepting edge. When the echo's first bit is sampled k edges after launch, that value is k+16.
- R5: A returned frame with a wrong address, command, tag, start pattern or check nibble is ignored, and the master keeps waiting for a matching echo.
- R6: If no matching echo is accepted by the 4095th edge after launch, done_timeout pulses on that edge and the node's table entry keeps its previous value.
- R7: req_ready is low from the edge that accepts a request until that request completes, so only one command is outstanding.
- R8: A rising edge on tick causes a broadcast frame with address 1111, command 10 and tag 00 (0xAF87) and gives no status pulse. A tick that arrives while the master is busy is held and sent once the master is idle, ahead of any host request.
- R9: A host request to address 1111 is sent as a broadcast. It completes with done_ack 17 edges after launch and does not wait for an echo.
- R10: The delay table has 16 entries of 12 bits. rd_delay shows the entry addressed by rd_addr one clock after rd_addr is sampled.
- R11: done_ack and done_timeout are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host command request |
| req_ready | output | 1 | Master can accept a request |
| req_addr | input | 4 | Target node address (1111 = broadcast) |
| req_cmd | input | 2 | Command code |
| tick | input | 1 | Periodic tick; a rising edge triggers a broadcast cycle increment |
| tx_line | output | 1 | Serial command line to the bus |
| rx_line | input | 1 | Serial return line from the bus |
| done_ack | output | 1 | Request acknowledged (one-cycle pulse) |
| done_timeout | output | 1 | Request timed out (one-cycle pulse) |
| rd_addr | input | 4 | Delay table read address |
| rd_delay | output | 12 | Loop delay read data |

## Verification
Assertions check on every cycle that the two status outputs are exclusive and that an accepted request drops req_ready. They also check that the serializer is never reloaded mid-frame and is quiet whenever the controller is idle, that a pending tick is served on the next cycle from idle, that the round-trip counter stays inside its window, and that a timeout comes only from a wait that reached the limit. Only the bench scenarios show the exact bit contents of frames, the tag sequence, the measured delay values, and the exact cycle counts to acknowledgement and timeout. They also show that corrupted echoes leave the wait running, that stored delays survive a timeout, and that a tick is deferred while a request is outstanding.

// File: rtl/cmd_link_pkg.sv
package cmd_link_pkg;
  localparam int ADDR_W  = 4;
  localparam int CMD_W   = 2;
  localparam int TAG_W   = 2;
  localparam int CHK_W   = ADDR_W;
  localparam int SYNC_W  = 4;
  localparam int FRAME_W = SYNC_W + ADDR_W + CMD_W + TAG_W + CHK_W;

  localparam logic [SYNC_W-1:0] SYNC_PAT   = 4'b1010;
  localparam logic [ADDR_W-1:0] BCAST_ADDR = '1;

  typedef enum logic [CMD_W-1:0] {
    CMD_LOGIC_RST = 2'b00,
    CMD_CPU_BOOT  = 2'b01,
    CMD_CYCLE_INC = 2'b10,
    CMD_SPARE     = 2'b11
  } node_cmd_e;

  typedef struct packed {
    logic [SYNC_W-1:0] sync;
    logic [ADDR_W-1:0] addr;
    logic [CMD_W-1:0]  cmd;
    logic [TAG_W-1:0]  tag;
    logic [CHK_W-1:0]  chk;
  } link_frame_t;

  function automatic link_frame_t make_frame(input logic [ADDR_W-1:0] a,
                                             input logic [CMD_W-1:0]  c,
                                             input logic [TAG_W-1:0]  t);
    link_frame_t f;
    f.sync = SYNC_PAT;
    f.addr = a;
    f.cmd  = c;
    f.tag  = t;
    f.chk  = a ^ {c, t};
    return f;
  endfunction
endpackage

// File: rtl/cmd_frame_tx.sv
module cmd_frame_tx #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  output logic               tx_line,
  output logic               busy
);
  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   left;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      left  <= '0;
    end else if (load) begin
      shreg <= frame;
      left  <= CNT_W'(FRAME_W);
    end else if (left != '0) begin
      shreg <= {shreg[FRAME_W-2:0], 1'b0};
      left  <= left - 1'b1;
    end
  end

  assign tx_line = shreg[FRAME_W-1];
  assign busy    = (left != '0);

  // R7: a new frame is never loaded over one still being shifted out
  p_load_when_free_r7: assert property (@(posedge clk) disable iff (rst)
    load |-> !busy);
endmodule

// File: rtl/cmd_frame_rx.sv
module cmd_frame_rx #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rx_line,
  output logic               frame_valid,
  output logic [FRAME_W-1:0] frame
);
  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic               active;
  logic [CNT_W-1:0]   got;
  logic [FRAME_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      active      <= 1'b0;
      got         <= '0;
      shreg       <= '0;
      frame       <= '0;
      frame_valid <= 1'b0;
    end else begin
      frame_valid <= 1'b0;
      if (!active) begin
        if (rx_line) begin
          active <= 1'b1;
          shreg  <= {{(FRAME_W-1){1'b0}}, 1'b1};
          got    <= CNT_W'(1);
        end
      end else begin
        shreg <= {shreg[FRAME_W-2:0], rx_line};
        if (got == CNT_W'(FRAME_W - 1)) begin
          active      <= 1'b0;
          got         <= '0;
          frame       <= {shreg[FRAME_W-2:0], rx_line};
          frame_valid <= 1'b1;
        end else begin
          got <= got + 1'b1;
        end
      end
    end
  end

  // R5: a complete frame takes a full frame time, so valid never repeats back to back
  p_rx_spacing_r5: assert property (@(posedge clk) disable iff (rst)
    frame_valid |=> !frame_valid);
endmodule

// File: rtl/cmd_delay_table.sv
module cmd_delay_table #(
  parameter int DEPTH = 16,
  parameter int DW    = 12,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0]    mem [DEPTH];
  logic [DW-1:0]    rd_q;
  logic [DEPTH-1:0] written;
  logic             written_q;

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_q <= mem[rd_addr];
  end

  // per-entry valid flags give the cleared-on-reset view
  always_ff @(posedge clk) begin
    if (rst) begin
      written   <= '0;
      written_q <= 1'b0;
    end else begin
      written_q <= written[rd_addr];
      if (wr_en) written[wr_addr] <= 1'b1;
    end
  end

  assign rd_data = written_q ? rd_q : '0;
endmodule

// File: rtl/cmd_link_master.sv
module cmd_link_master
  import cmd_link_pkg::*;
#(
  parameter int DLY_W   = 12,
  parameter int TMO_CYC = 4095
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CMD_W-1:0]  req_cmd,
  input  logic              tick,
  output logic              tx_line,
  input  logic              rx_line,
  output logic              done_ack,
  output logic              done_timeout,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DLY_W-1:0]  rd_delay
);
  localparam int NODES = 2 ** ADDR_W;
  localparam logic [DLY_W-1:0] TMO_LIM = DLY_W'(TMO_CYC);

  typedef enum logic [1:0] {S_IDLE, S_BCAST, S_WAIT} mst_state_e;

  mst_state_e         state;
  logic               tick_s1, tick_s2, tick_rise;
  logic               bc_pend, host_bc;
  logic [TAG_W-1:0]   seq_tag;
  link_frame_t        sent_frame;
  logic [DLY_W-1:0]   loop_cnt;
  logic               launch_bc, launch_req, tx_load, tx_busy;
  link_frame_t        tx_frame;
  logic               rx_valid;
  logic [FRAME_W-1:0] rx_frame;
  logic               echo_match, tbl_we;

  assign tick_rise  = tick_s1 & ~tick_s2;
  assign req_ready  = (state == S_IDLE) && !bc_pend;
  assign launch_bc  = (state == S_IDLE) && bc_pend;
  assign launch_req = req_valid && req_ready;
  assign tx_load    = launch_bc || launch_req;

  always_comb begin
    if (bc_pend)
      tx_frame = make_frame(BCAST_ADDR, CMD_CYCLE_INC, '0);
    else if (req_addr == BCAST_ADDR)
      tx_frame = make_frame(req_addr, req_cmd, '0);
    else
      tx_frame = make_frame(req_addr, req_cmd, seq_tag);
  end

  assign echo_match = rx_valid && (rx_frame == FRAME_W'(sent_frame));
  assign tbl_we     = (state == S_WAIT) && echo_match;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_IDLE;
      tick_s1      <= 1'b0;
      tick_s2      <= 1'b0;
      bc_pend      <= 1'b0;
      host_bc      <= 1'b0;
      seq_tag      <= '0;
      sent_frame   <= '0;
      loop_cnt     <= '0;
      done_ack     <= 1'b0;
      done_timeout <= 1'b0;
    end else begin
      done_ack     <= 1'b0;
      done_timeout <= 1'b0;
      tick_s1      <= tick;
      tick_s2      <= tick_s1;
      if (launch_bc) bc_pend <= 1'b0;
      if (tick_rise) bc_pend <= 1'b1;
      unique case (state)
        S_IDLE: begin
          if (launch_bc) begin
            state   <= S_BCAST;
            host_bc <= 1'b0;
          end else if (launch_req) begin
            if (req_addr == BCAST_ADDR) begin
              state   <= S_BCAST;
              host_bc <= 1'b1;
            end else begin
              state      <= S_WAIT;
              sent_frame <= tx_frame;
              seq_tag    <= seq_tag + 1'b1;
              loop_cnt   <= DLY_W'(1);
            end
          end
        end
        S_BCAST: begin
          if (!tx_busy) begin
            state    <= S_IDLE;
            done_ack <= host_bc;
          end
        end
        S_WAIT: begin
          if (echo_match) begin
            done_ack <= 1'b1;
            state    <= S_IDLE;
          end else if (loop_cnt == TMO_LIM) begin
            done_timeout <= 1'b1;
            state        <= S_IDLE;
          end else begin
            loop_cnt <= loop_cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  cmd_frame_tx #(.FRAME_W(FRAME_W)) u_tx (
    .clk     (clk),
    .rst     (rst),
    .load    (tx_load),
    .frame   (FRAME_W'(tx_frame)),
    .tx_line (tx_line),
    .busy    (tx_busy)
  );

  cmd_frame_rx #(.FRAME_W(FRAME_W)) u_rx (
    .clk         (clk),
    .rst         (rst),
    .rx_line     (rx_line),
    .frame_valid (rx_valid),
    .frame       (rx_frame)
  );

  cmd_delay_table #(.DEPTH(NODES), .DW(DLY_W)) u_tbl (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (tbl_we),
    .wr_addr (sent_frame.addr),
    .wr_data (loop_cnt),
    .rd_addr (rd_addr),
    .rd_data (rd_delay)
  );

  // R11: the two completion pulses are exclusive
  p_status_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(done_ack && done_timeout));

  // R7: an accepted request closes the request port on the next cycle
  p_one_outstanding_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R1: the serial line is quiet whenever the controller is idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE) |-> !tx_busy);

  // R8: a held tick is launched straight from idle
  p_tick_served_r8: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && bc_pend) |=> (state == S_BCAST));

  // R6: the round-trip counter stays inside its window while waiting
  p_window_r6: assert property (@(posedge clk) disable iff (rst)
    (state == S_WAIT) |-> (loop_cnt != '0 && loop_cnt <= TMO_LIM));

  // R6: a timeout only follows a wait that reached the limit
  p_timeout_src_r6: assert property (@(posedge clk) disable iff (rst)
    done_timeout |-> ($past(state) == S_WAIT && $past(loop_cnt) == TMO_LIM));
endmodule

// File: tb/cmd_link_master_tb.sv
module cmd_link_master_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_addr = '0;
  logic [1:0]  req_cmd = '0;
  logic        tick = 1'b0;
  logic        tx_line;
  logic        rx_line = 1'b0;
  logic        done_ack, done_timeout;
  logic [3:0]  rd_addr = '0;
  logic [11:0] rd_delay;

  always #2.5 clk = ~clk;

  cmd_link_master u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_cmd(req_cmd), .tick(tick), .tx_line(tx_line),
    .rx_line(rx_line), .done_ack(done_ack), .done_timeout(done_timeout),
    .rd_addr(rd_addr), .rd_delay(rd_delay)
  );

  int n_checks = 0;
  int n_err    = 0;
  bit finished = 0;

  task automatic check_eq(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- node model: captures frames, returns echoes ----------------
  bit          node_en   = 1;
  int          node_gap  = 1;
  int          node_mode = 0;
  logic [15:0] cap_sh    = '0;
  int          cap_bits  = 0;
  bit          cap_act   = 0;
  logic [15:0] last_cap  = '0;
  int          cap_count = 0;
  logic [63:0] ebuf      = '0;
  int          elen      = 0;
  int          ewait     = 0;
  bit          sending   = 0;

  always @(negedge clk) begin
    if (ewait > 0) begin
      ewait = ewait - 1;
      if (ewait == 0) sending = 1;
    end
    if (sending && elen > 0) begin
      rx_line = ebuf[63];
      ebuf    = ebuf << 1;
      elen    = elen - 1;
    end else begin
      rx_line = 1'b0;
      sending = 0;
    end
    if (!cap_act) begin
      if (tx_line) begin
        cap_act  = 1;
        cap_sh   = 16'h0001;
        cap_bits = 1;
      end
    end else begin
      cap_sh   = {cap_sh[14:0], tx_line};
      cap_bits = cap_bits + 1;
      if (cap_bits == 16) begin
        cap_act   = 0;
        last_cap  = cap_sh;
        cap_count = cap_count + 1;
        if (node_en && cap_sh[11:8] != 4'hF) begin
          case (node_mode)
            1: begin ebuf = {cap_sh ^ 16'h0001, 48'h0}; elen = 16; end
            2: begin ebuf = {cap_sh ^ 16'h0011, 2'b00, cap_sh, 30'h0}; elen = 34; end
            3: begin ebuf = {cap_sh ^ 16'h0101, 48'h0}; elen = 16; end
            default: begin ebuf = {cap_sh, 48'h0}; elen = 16; end
          endcase
          ewait = node_gap;
        end
      end
    end
  end

  int ack_seen = 0;
  int both_seen = 0;
  always @(negedge clk) begin
    if (done_ack) ack_seen++;
    if (done_ack && done_timeout) both_seen++;
  end

  // ---------------- helpers ----------------
  int exp_tag = 0;

  function automatic logic [15:0] exp_frame(logic [3:0] a, logic [1:0] c, logic [1:0] t);
    return {4'b1010, a, c, t, a ^ {c, t}};
  endfunction

  // kind: 1 = ack, 2 = timeout, 0 = none; n = edges from launch to status
  task automatic do_req(input logic [3:0] a, input logic [1:0] c,
                        output int n, output int kind, output int ready_bad);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    req_cmd   = c;
    @(posedge clk);
    #1 req_valid = 1'b0;
    @(negedge clk);
    n = 0; kind = 0; ready_bad = 0;
    while (1) begin
      if (done_ack) kind = 1;
      else if (done_timeout) kind = 2;
      if (kind != 0) break;
      if (req_ready) ready_bad++;
      @(posedge clk);
      n++;
      @(negedge clk);
      if (n > 6000) break;
    end
  endtask

  task automatic read_delay(input logic [3:0] a, output int v);
    @(negedge clk) rd_addr = a;
    @(posedge clk);
    @(negedge clk) v = rd_delay;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset_state();
    int v, nz;
    @(negedge clk);
    check_eq("R2", "req_ready after reset", req_ready, 1);
    check_eq("R2", "tx_line idle after reset", tx_line, 0);
    check_eq("R2", "status pulses after reset", done_ack | done_timeout, 0);
    nz = 0;
    for (int i = 0; i < 16; i++) begin
      read_delay(4'(i), v);
      if (v != 0) nz++;
    end
    check_eq("R2", "nonzero table entries after reset", nz, 0);
  endtask

  task automatic t_echo_ack(logic [3:0] a, logic [1:0] c, int gap);
    int n, kind, rb, v;
    node_en = 1; node_mode = 0; node_gap = gap;
    do_req(a, c, n, kind, rb);
    check_eq("R4", "echo status is ack", kind, 1);
    check_eq("R4", "edges launch to ack", n, 32 + gap);
    check_eq("R1", "sent frame bits", last_cap, exp_frame(a, c, 2'(exp_tag)));
    check_eq("R7", "ready high while outstanding", rb, 0);
    exp_tag = (exp_tag + 1) % 4;
    read_delay(a, v);
    check_eq("R10", "stored loop delay", v, 32 + gap);
  endtask

  task automatic t_ignored_echo();
    int n, kind, rb, v;
    node_en = 1; node_mode = 2; node_gap = 4;
    do_req(4'd3, 2'd0, n, kind, rb);
    check_eq("R5", "ack after wrong-tag echo", kind, 1);
    check_eq("R5", "edges with bad echo first", n, 54);
    check_eq("R3", "tag wrap to 00", last_cap[5:4], exp_tag);
    exp_tag = (exp_tag + 1) % 4;
    read_delay(4'd3, v);
    check_eq("R5", "delay from matching echo", v, 54);
  endtask

  task automatic t_timeouts();
    int n, kind, rb, v;
    node_en = 1; node_mode = 1; node_gap = 2;
    do_req(4'd7, 2'd1, n, kind, rb);
    check_eq("R6", "bad check nibble gives timeout", kind, 2);
    check_eq("R6", "edges launch to timeout", n, 4095);
    exp_tag = (exp_tag + 1) % 4;
    read_delay(4'd7, v);
    check_eq("R6", "delay kept after timeout", v, 41);
    node_mode = 3;
    do_req(4'd0, 2'd2, n, kind, rb);
    check_eq("R5", "wrong address echo ignored", kind, 2);
    exp_tag = (exp_tag + 1) % 4;
    read_delay(4'd0, v);
    check_eq("R6", "node 0 delay kept", v, 72);
    check_eq("R7", "ready high during timeout wait", rb, 0);
  endtask

  task automatic t_tick_bcast();
    int cc, acks;
    cc = cap_count; acks = ack_seen;
    @(negedge clk) tick = 1'b1;
    repeat (3) @(negedge clk);
    tick = 1'b0;
    repeat (40) @(negedge clk);
    check_eq("R8", "broadcast frames sent", cap_count, cc + 1);
    check_eq("R8", "broadcast frame bits", last_cap, 16'hAF87);
    check_eq("R8", "no status for tick broadcast", ack_seen, acks);
    check_eq("R8", "ready back after broadcast", req_ready, 1);
  endtask

  task automatic t_tick_during_wait();
    int n, kind, rb, cc;
    cc = cap_count;
    node_en = 1; node_mode = 0; node_gap = 20;
    fork
      do_req(4'd5, 2'd2, n, kind, rb);
      begin
        repeat (10) @(negedge clk);
        tick = 1'b1;
        repeat (3) @(negedge clk);
        tick = 1'b0;
      end
    join
    check_eq("R8", "unicast ack with tick pending", kind, 1);
    check_eq("R8", "unicast delay unaffected", n, 52);
    exp_tag = (exp_tag + 1) % 4;
    repeat (40) @(negedge clk);
    check_eq("R8", "frames: unicast then held broadcast", cap_count, cc + 2);
    check_eq("R8", "held broadcast frame bits", last_cap, 16'hAF87);
  endtask

  task automatic t_host_bcast();
    int n, kind, rb, v;
    do_req(4'hF, 2'd1, n, kind, rb);
    check_eq("R9", "host broadcast acked", kind, 1);
    check_eq("R9", "edges to host broadcast ack", n, 17);
    check_eq("R9", "host broadcast frame bits", last_cap, 16'hAF4B);
    read_delay(4'hF, v);
    check_eq("R9", "broadcast entry untouched", v, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    t_reset_state();
    t_echo_ack(4'd3, 2'd0, 1);
    t_echo_ack(4'd7, 2'd1, 9);
    t_echo_ack(4'd0, 2'd2, 40);
    t_echo_ack(4'd14, 2'd3, 2);
    t_ignored_echo();
    t_timeouts();
    t_tick_bcast();
    t_tick_during_wait();
    t_host_bcast();
    t_echo_ack(4'd9, 2'd2, 3);   // R3: tag continues after broadcasts
    check_eq("R11", "cycles with both pulses", both_seen, 0);
    finish_run();
  end
endmodule